// File: doc/BRIEF.md
# Slow-Control Serial Bus Master

This block runs one transaction at a time on a three-wire slow-control bus: a bus clock line driven by the master, a master-to-card data line and a card-to-master data line. A host presents a command (read or write, 4-bit card number, broadcast flag, 5-bit register number, 16-bit write word) and pulses a start input. The block packs the command into a fixed 32-bit frame and shifts it out least-significant bit first. The frame is two header bytes followed by two data bytes, with a start condition before it and a stop condition after it. After every byte a ninth bus clock carries the card's acknowledge, and the master samples it.

The result register holds a status code and, for reads, the 16-bit word the card returned. It is updated once per command and then kept until the next one. A one-cycle done pulse marks each update. A missing acknowledge ends the frame early with a stop condition, unless the command is a broadcast write. A broadcast read is refused at once, and the bus stays idle. The bus clock is the system clock divided by a parameter.

Top module: `sc_bus_master`

## Requirements
- R1: After reset, scl and sda_out are 1, busy and done are 0, and res_status is 0.
- R2: A complete transaction has four parts in order. First comes a start condition: sda_out falls while scl stays high, for one bus period. Then come 36 bit slots, which are four bytes of 9 slots each, the ninth slot being the acknowledge. Last comes a stop condition, in which sda_out is 0 through one bus period and rises only after scl is high.
- R3: The first byte carries the command. Bit 0 is 1 for read and 0 for write, bits 1 to 4 hold the card number, bit 6 is the broadcast flag, and bits 5 and 7 are sent as 0. The master presents each bit on sda_out while scl is low, bit 0 first.
- R4: The second byte carries the register number in bits 0 to 4, and bits 5 to 7 are sent as 0.
- R5: For a write, byte 3 is cmd_wdata[7:0] and byte 4 is cmd_wdata[15:8], each sent bit 0 first.
- R6: For a read, the master holds sda_out at 1 during the 16 data-bit slots and samples sda_in instead. The first sampled bit becomes res_rdata[0] and the last becomes res_rdata[15].
- R7: In every acknowledge slot sda_out is 1, and sda_in is sampled at the end of the high half of scl, with 0 meaning acknowledge. For a command that is not a broadcast write, a 1 ends the frame: the stop condition follows that slot at once, res_status becomes 1, and res_rdata becomes 0.
- R8: For a broadcast write, acknowledge values are ignored. The full frame is sent and res_status becomes 0.
- R9: A broadcast read makes no bus activity. done pulses one cycle after the start pulse, res_status becomes 2, res_rdata becomes 0, and busy stays 0.
- R10: busy is 1 from the cycle after an accepted start pulse until the result is written. A start pulse while busy is ignored, and the frame in flight is unchanged.
- R11: One bus period is 2*HALF_DIV system clocks, with scl low for the first HALF_DIV clocks and high for the rest.
- R12: done is a single-cycle pulse coinciding with the result update, and the result stays unchanged until the next command completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | One-cycle request to run the presented command |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_card | input | 4 | Target card number |
| cmd_bcast | input | 1 | Broadcast flag |
| cmd_reg | input | 5 | Register number on the card |
| cmd_wdata | input | 16 | Write word |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse when the result is updated |
| res_status | output | 2 | 0 = ok, 1 = missing acknowledge, 2 = broadcast read refused |
| res_rdata | output | 16 | Word read from the card |
| scl | output | 1 | Bus clock |
| sda_out | output | 1 | Master-to-card data line |
| sda_in | input | 1 | Card-to-master data line |

## Verification
Two events can land in the same cycle. One is a new start pulse arriving while a frame is in flight: the bench raises it with different command fields mid-frame, then compares every captured bus bit against the first command. The other is a missing acknowledge on the last byte, which coincides with the point where the frame would end anyway: the bench withholds only that acknowledge. It then expects the full 36 slots followed by a stop, together with status 1 rather than 0. A card model driven by the bus lines decodes each slot, supplies acknowledges and read bits, and measures the bus clock halves.

// File: rtl/sc_bus_pkg.sv
package sc_bus_pkg;

    localparam int CARD_W      = 4;
    localparam int REG_W       = 5;
    localparam int DATA_W      = 16;
    localparam int BYTE_BITS   = 8;
    localparam int HDR_BYTES   = 2;
    localparam int FRAME_BYTES = HDR_BYTES + DATA_W / BYTE_BITS;
    localparam int FRAME_BITS  = FRAME_BYTES * BYTE_BITS;
    localparam int ACK_SLOT    = BYTE_BITS;

    typedef struct packed {
        logic              rd;
        logic [CARD_W-1:0] card;
        logic              bcast;
        logic [REG_W-1:0]  regad;
        logic [DATA_W-1:0] wdata;
    } cmd_t;

    typedef enum logic [1:0] {
        ST_OK       = 2'd0,
        ST_NACK     = 2'd1,
        ST_BCAST_RD = 2'd2
    } res_status_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_START,
        S_BITS,
        S_STOP
    } seq_state_e;

    // Header layout: byte 0 = {x, bcast, x, card[3:0], rd}, byte 1 = {x, x, x, reg[4:0]}
    function automatic logic [FRAME_BITS-1:0] pack_frame(input cmd_t c);
        logic [BYTE_BITS-1:0] hdr_cmd;
        logic [BYTE_BITS-1:0] hdr_reg;
        hdr_cmd      = '0;
        hdr_cmd[0]   = c.rd;
        hdr_cmd[4:1] = c.card;
        hdr_cmd[6]   = c.bcast;
        hdr_reg      = '0;
        hdr_reg[REG_W-1:0] = c.regad;
        return {c.wdata, hdr_reg, hdr_cmd};
    endfunction

endpackage

// File: rtl/sc_bus_clkdiv.sv
module sc_bus_clkdiv #(
    parameter int HALF_DIV = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    output logic half_tick_o
);

    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    assign half_tick_o = en_i && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    generate
        if (HALF_DIV > 1) begin : g_gap_chk
            // R11: half-period strobes never come back to back
            a_r11_tick_gap: assert property (@(posedge clk) disable iff (rst)
                half_tick_o |=> !half_tick_o);
        end
    endgenerate

endmodule

// File: rtl/sc_frame_pack.sv
module sc_frame_pack
    import sc_bus_pkg::*;
(
    input  cmd_t                  cmd_i,
    output logic [FRAME_BITS-1:0] frame_o,
    output logic [FRAME_BITS-1:0] drive_o
);

    assign frame_o = pack_frame(cmd_i);

    // Master drives every bit except the data bytes of a read
    generate
        for (genvar b = 0; b < FRAME_BYTES; b++) begin : g_byte
            if (b < HDR_BYTES) begin : g_hdr
                assign drive_o[b*BYTE_BITS +: BYTE_BITS] = '1;
            end else begin : g_dat
                assign drive_o[b*BYTE_BITS +: BYTE_BITS] = {BYTE_BITS{!cmd_i.rd}};
            end
        end
    endgenerate

endmodule

// File: rtl/sc_bus_seq.sv
module sc_bus_seq
    import sc_bus_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  half_tick_i,
    input  logic                  start_i,
    input  cmd_t                  cmd_i,
    input  logic [FRAME_BITS-1:0] frame_i,
    input  logic [FRAME_BITS-1:0] drive_i,
    input  logic                  sda_in_i,
    output logic                  busy_o,
    output logic                  scl_o,
    output logic                  sda_out_o,
    output logic                  done_o,
    output res_status_e           status_o,
    output logic [DATA_W-1:0]     rdata_o
);

    localparam logic [3:0] ACK_IDX   = 4'(ACK_SLOT);
    localparam logic [1:0] LAST_BYTE = 2'(FRAME_BYTES - 1);

    seq_state_e             state;
    logic                   phase;
    logic [3:0]             bitcnt;
    logic [1:0]             bytecnt;
    logic [FRAME_BITS-1:0]  frame_q;
    logic [FRAME_BITS-1:0]  drive_q;
    cmd_t                   cmd_q;
    logic [DATA_W-1:0]      rdata_q;
    logic                   nack_q;
    logic                   tick_end;
    logic                   ack_bad;

    assign busy_o   = (state != S_IDLE);
    assign tick_end = half_tick_i && phase;
    assign ack_bad  = sda_in_i && !(cmd_q.bcast && !cmd_q.rd);

    always_comb begin
        unique case (state)
            S_IDLE: begin
                scl_o     = 1'b1;
                sda_out_o = 1'b1;
            end
            S_START: begin
                scl_o     = 1'b1;
                sda_out_o = 1'b0;
            end
            S_BITS: begin
                scl_o = phase;
                if (bitcnt == ACK_IDX) begin
                    sda_out_o = 1'b1;
                end else begin
                    sda_out_o = drive_q[0] ? frame_q[0] : 1'b1;
                end
            end
            default: begin
                scl_o     = phase;
                sda_out_o = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            phase    <= 1'b0;
            bitcnt   <= '0;
            bytecnt  <= '0;
            frame_q  <= '0;
            drive_q  <= '0;
            cmd_q    <= '0;
            rdata_q  <= '0;
            nack_q   <= 1'b0;
            done_o   <= 1'b0;
            status_o <= ST_OK;
            rdata_o  <= '0;
        end else begin
            done_o <= 1'b0;
            if (state != S_IDLE && half_tick_i) begin
                phase <= ~phase;
            end
            unique case (state)
                S_IDLE: begin
                    if (start_i) begin
                        if (cmd_i.rd && cmd_i.bcast) begin
                            done_o   <= 1'b1;
                            status_o <= ST_BCAST_RD;
                            rdata_o  <= '0;
                        end else begin
                            state   <= S_START;
                            cmd_q   <= cmd_i;
                            frame_q <= frame_i;
                            drive_q <= drive_i;
                            rdata_q <= '0;
                            nack_q  <= 1'b0;
                            phase   <= 1'b0;
                            bitcnt  <= '0;
                            bytecnt <= '0;
                        end
                    end
                end
                S_START: begin
                    if (tick_end) begin
                        state <= S_BITS;
                    end
                end
                S_BITS: begin
                    if (tick_end) begin
                        if (bitcnt == ACK_IDX) begin
                            if (ack_bad) begin
                                nack_q <= 1'b1;
                                state  <= S_STOP;
                            end else if (bytecnt == LAST_BYTE) begin
                                state <= S_STOP;
                            end else begin
                                bytecnt <= bytecnt + 2'd1;
                                bitcnt  <= '0;
                            end
                        end else begin
                            frame_q <= frame_q >> 1;
                            drive_q <= drive_q >> 1;
                            if (!drive_q[0]) begin
                                rdata_q <= {sda_in_i, rdata_q[DATA_W-1:1]};
                            end
                            bitcnt <= bitcnt + 4'd1;
                        end
                    end
                end
                default: begin
                    if (tick_end) begin
                        state    <= S_IDLE;
                        done_o   <= 1'b1;
                        status_o <= nack_q ? ST_NACK : ST_OK;
                        rdata_o  <= (nack_q || !cmd_q.rd) ? '0 : rdata_q;
                    end
                end
            endcase
        end
    end

    // R2: bit slot index stays within a byte plus its acknowledge
    a_r2_slot_range: assert property (@(posedge clk) disable iff (rst)
        bitcnt <= ACK_IDX);

    // R11: the bus clock only moves on a divider strobe
    a_r11_scl_on_tick: assert property (@(posedge clk) disable iff (rst)
        !$stable(scl_o) |-> $past(half_tick_i));

    // R7: a refused acknowledge leads straight into the stop condition
    a_r7_nack_to_stop: assert property (@(posedge clk) disable iff (rst)
        (state == S_BITS && tick_end && bitcnt == ACK_IDX && ack_bad)
        |=> (state == S_STOP));

    // R9: broadcast read is answered without leaving idle
    a_r9_bcast_rd_idle: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && start_i && cmd_i.rd && cmd_i.bcast)
        |=> (state == S_IDLE && done_o && status_o == ST_BCAST_RD));

    // R10: a start pulse during a frame leaves the latched command alone
    a_r10_busy_ignores_start: assert property (@(posedge clk) disable iff (rst)
        (state != S_IDLE && start_i) |=> $stable(cmd_q));

    // R12: done lasts exactly one cycle
    a_r12_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

endmodule

// File: rtl/sc_bus_master.sv
module sc_bus_master
    import sc_bus_pkg::*;
#(
    parameter int HALF_DIV = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_start,
    input  logic              cmd_read,
    input  logic [CARD_W-1:0] cmd_card,
    input  logic              cmd_bcast,
    input  logic [REG_W-1:0]  cmd_reg,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              busy,
    output logic              done,
    output logic [1:0]        res_status,
    output logic [DATA_W-1:0] res_rdata,
    output logic              scl,
    output logic              sda_out,
    input  logic              sda_in
);

    cmd_t                  cmd;
    logic [FRAME_BITS-1:0] frame;
    logic [FRAME_BITS-1:0] drive;
    logic                  half_tick;
    res_status_e           status;

    assign cmd.rd    = cmd_read;
    assign cmd.card  = cmd_card;
    assign cmd.bcast = cmd_bcast;
    assign cmd.regad = cmd_reg;
    assign cmd.wdata = cmd_wdata;
    assign res_status = status;

    sc_bus_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
        .clk         (clk),
        .rst         (rst),
        .en_i        (busy),
        .half_tick_o (half_tick)
    );

    sc_frame_pack u_pack (
        .cmd_i   (cmd),
        .frame_o (frame),
        .drive_o (drive)
    );

    sc_bus_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .half_tick_i (half_tick),
        .start_i     (cmd_start),
        .cmd_i       (cmd),
        .frame_i     (frame),
        .drive_i     (drive),
        .sda_in_i    (sda_in),
        .busy_o      (busy),
        .scl_o       (scl),
        .sda_out_o   (sda_out),
        .done_o      (done),
        .status_o    (status),
        .rdata_o     (res_rdata)
    );

endmodule

// File: tb/sc_bus_master_test.sv
module sc_bus_master_test;

    localparam int HD = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_start;
    logic        cmd_read;
    logic [3:0]  cmd_card;
    logic        cmd_bcast;
    logic [4:0]  cmd_reg;
    logic [15:0] cmd_wdata;
    logic        busy;
    logic        done;
    logic [1:0]  res_status;
    logic [15:0] res_rdata;
    logic        scl;
    logic        sda_out;
    logic        sda_in;

    int n_chk  = 0;
    int n_fail = 0;

    // card model state
    int          slot = -1;
    int          starts = 0;
    logic [3:0]  cfg_nack = 4'h0;
    logic        cfg_rd = 1'b0;
    logic [15:0] cfg_rword = 16'h0;
    logic [31:0] cap = '0;

    // latched results
    logic [1:0]  got_status;
    logic [15:0] got_rdata;
    logic        got_done;
    logic        busy_after;

    always #4 clk = ~clk;

    sc_bus_master #(.HALF_DIV(HD)) uut (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_read(cmd_read),
        .cmd_card(cmd_card), .cmd_bcast(cmd_bcast), .cmd_reg(cmd_reg),
        .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
        .res_status(res_status), .res_rdata(res_rdata),
        .scl(scl), .sda_out(sda_out), .sda_in(sda_in)
    );

    // start condition detector
    initial begin
        forever begin
            @(negedge sda_out);
            #1;
            if (scl === 1'b1) begin
                slot   = -1;
                starts = starts + 1;
            end
        end
    end

    // card drives its line while scl is low
    initial begin
        sda_in = 1'b1;
        forever begin
            @(negedge scl);
            slot = slot + 1;
            if (slot >= 0 && slot < 36) begin
                if (slot % 9 == 8) begin
                    sda_in = cfg_nack[slot / 9];
                end else if (cfg_rd && slot / 9 >= 2) begin
                    sda_in = cfg_rword[(slot / 9 - 2) * 8 + slot % 9];
                end else begin
                    sda_in = 1'b1;
                end
            end else begin
                sda_in = 1'b1;
            end
        end
    end

    // card samples master data on scl rising
    initial begin
        forever begin
            @(posedge scl);
            if (slot >= 0 && slot < 36 && slot % 9 != 8) begin
                cap[(slot / 9) * 8 + slot % 9] = sda_out;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_frame(input logic rd, input logic [3:0] card,
                                              input logic bc, input logic [4:0] rg,
                                              input logic [15:0] wd);
        logic [7:0] a;
        logic [7:0] b;
        a = {1'b0, bc, 1'b0, card, rd};
        b = {3'b000, rg};
        return {(rd ? 16'hFFFF : wd), b, a};
    endfunction

    task automatic start_cmd(input logic rd, input logic [3:0] card, input logic bc,
                             input logic [4:0] rg, input logic [15:0] wd);
        @(negedge clk);
        cmd_read  = rd;
        cmd_card  = card;
        cmd_bcast = bc;
        cmd_reg   = rg;
        cmd_wdata = wd;
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start  = 1'b0;
        busy_after = busy;
    endtask

    task automatic wait_done();
        got_done = 1'b0;
        if (done === 1'b1) begin
            got_done = 1'b1;
        end
        for (int i = 0; i < 4000 && !got_done; i++) begin
            @(negedge clk);
            if (done === 1'b1) got_done = 1'b1;
        end
        got_status = res_status;
        got_rdata  = res_rdata;
    endtask

    task automatic t_reset();
        chk("R1 scl idle", 32'(scl), 32'd1);
        chk("R1 sda_out idle", 32'(sda_out), 32'd1);
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 status", 32'(res_status), 32'd0);
    endtask

    task automatic t_write();
        cfg_nack = 4'h0; cfg_rd = 1'b0; starts = 0;
        start_cmd(1'b0, 4'hA, 1'b0, 5'h13, 16'hC35A);
        chk("R10 busy after start", 32'(busy_after), 32'd1);
        wait_done();
        chk("R12 done seen", 32'(got_done), 32'd1);
        @(negedge clk);
        chk("R12 done one cycle", 32'(done), 32'd0);
        chk("R10 busy cleared", 32'(busy), 32'd0);
        chk("R2 one start", 32'(starts), 32'd1);
        chk("R2 slot count", 32'(slot), 32'd36);
        chk("R3 command byte", 32'(cap[7:0]), 32'(exp_frame(1'b0, 4'hA, 1'b0, 5'h13, 16'hC35A) & 32'hFF));
        chk("R4 register byte", 32'(cap[15:8]), 32'h13);
        chk("R5 write data", 32'(cap[31:16]), 32'hC35A);
        chk("R7 status ok", 32'(got_status), 32'd0);
        chk("R2 sda idle after stop", 32'(sda_out), 32'd1);
    endtask

    task automatic t_read();
        cfg_nack = 4'h0; cfg_rd = 1'b1; cfg_rword = 16'h9E61;
        start_cmd(1'b1, 4'h3, 1'b0, 5'h07, 16'h1234);
        wait_done();
        chk("R6 read word", 32'(got_rdata), 32'h9E61);
        chk("R6 line released", 32'(cap[31:16]), 32'hFFFF);
        chk("R3 read header", 32'(cap[15:0]), 32'(exp_frame(1'b1, 4'h3, 1'b0, 5'h07, 16'h0) & 32'hFFFF));
        chk("R6 status ok", 32'(got_status), 32'd0);
        cfg_rd = 1'b0;
    endtask

    task automatic t_nack_mid();
        cfg_nack = 4'b0010;
        start_cmd(1'b0, 4'h5, 1'b0, 5'h01, 16'hFFFF);
        wait_done();
        chk("R7 nack status", 32'(got_status), 32'd1);
        chk("R7 frame cut", 32'(slot), 32'd18);
        chk("R7 rdata zero", 32'(got_rdata), 32'd0);
    endtask

    task automatic t_nack_last();
        cfg_nack = 4'b1000;
        start_cmd(1'b0, 4'h6, 1'b0, 5'h02, 16'h0F0F);
        wait_done();
        chk("R7 last-byte nack status", 32'(got_status), 32'd1);
        chk("R7 last-byte nack length", 32'(slot), 32'd36);
    endtask

    task automatic t_bcast_write();
        cfg_nack = 4'hF;
        start_cmd(1'b0, 4'h0, 1'b1, 5'h1F, 16'hA5A5);
        wait_done();
        chk("R8 bcast status", 32'(got_status), 32'd0);
        chk("R8 bcast full frame", 32'(slot), 32'd36);
        chk("R8 bcast flag bit6", 32'(cap[6]), 32'd1);
        cfg_nack = 4'h0;
    endtask

    task automatic t_bcast_read();
        starts = 0;
        slot = -1;
        start_cmd(1'b1, 4'h2, 1'b1, 5'h04, 16'h0);
        chk("R9 busy stays low", 32'(busy_after), 32'd0);
        chk("R9 done next cycle", 32'(done), 32'd1);
        chk("R9 status", 32'(res_status), 32'd2);
        chk("R9 rdata", 32'(res_rdata), 32'd0);
        repeat (3 * HD) @(negedge clk);
        chk("R9 no start", 32'(starts), 32'd0);
        chk("R9 no clocks", 32'(slot), 32'hFFFFFFFF);
        chk("R9 scl high", 32'(scl), 32'd1);
    endtask

    task automatic t_ignore_start();
        cfg_nack = 4'h0;
        start_cmd(1'b0, 4'h9, 1'b0, 5'h0C, 16'h3C96);
        repeat (40) @(negedge clk);
        cmd_read = 1'b0; cmd_card = 4'h1; cmd_reg = 5'h1A; cmd_wdata = 16'h0001;
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        wait_done();
        chk("R10 frame untouched", cap, exp_frame(1'b0, 4'h9, 1'b0, 5'h0C, 16'h3C96));
        chk("R10 single frame length", 32'(slot), 32'd36);
        repeat (20) @(negedge clk);
        chk("R12 result held", 32'(res_status), 32'(got_status));
        chk("R12 no spurious busy", 32'(busy), 32'd0);
    endtask

    task automatic t_rate();
        realtime t0, t1, t2;
        start_cmd(1'b0, 4'h4, 1'b0, 5'h05, 16'h5555);
        @(negedge scl); t0 = $realtime;
        @(posedge scl); t1 = $realtime;
        @(negedge scl); t2 = $realtime;
        wait_done();
        chk("R11 low half", 32'(int'((t1 - t0) / 8.0)), 32'(HD));
        chk("R11 period", 32'(int'((t2 - t0) / 8.0)), 32'(2 * HD));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        cmd_start = 1'b0; cmd_read = 1'b0; cmd_card = 4'h0;
        cmd_bcast = 1'b0; cmd_reg = 5'h0; cmd_wdata = 16'h0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_write();
        t_read();
        t_nack_mid();
        t_nack_last();
        t_bcast_write();
        t_bcast_read();
        t_ignore_start();
        t_rate();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule